// File: doc/BRIEF.md
# Strict and Weighted-Pool Hybrid Arbiter

This block picks at most one of eight requesters in every clock cycle. A programmable boundary count N splits the requesters into two classes. Indices 0 through N-1 form a weighted pool that shares bandwidth by deficit-style accounting. Every index from N upward is a strict-priority requester. Strict requesters always beat the pool, and among themselves the highest index wins.

Each requester presents a request bit and a length. Each pool member also has a programmable cost, and a larger cost buys a smaller share. Software computes the costs from the user's weights. The input with the smallest weight ends up with the largest cost, roughly the maximum cost scaled by the minimum weight over its own weight, minus one.

Inside the pool, every input owns an accumulator. The requesting pool member with the smallest accumulator is granted, and its accumulator then grows by (cost+1) times its length. The accumulators are then rebased against the smallest value among the requesting members, so that they stay bounded. The grant is registered: the one-hot grant and its valid flag appear in the cycle after the request pattern that produced them.

Top module: `prio_dwrr_arb`

## Requirements
- R1: While reset is active and directly after it, grant_o is all zero and grant_vld_o is low, and every pool accumulator starts at zero.
- R2: At each rising edge the block samples req_i. In the following cycle grant_vld_o is high exactly when some bit of req_i was set, and grant_o then has exactly one bit set, which belongs to a requesting input. With no request, grant_o is zero.
- R3: Input i belongs to the pool when i < pool_cnt_i. Any pool_cnt_i above 8 acts as 8, which puts every input in the pool. A pool_cnt_i of 0 makes every input strict.
- R4: When any strict input requests, the highest-indexed strict requester is granted and no pool input is granted.
- R5: With no strict request, the requesting pool input with the smallest accumulator is granted. On a tie, the lowest index wins.
- R6: A granted pool input i adds (cost_i[8i+7:8i] + 1) * len_i[8i+7:8i] to its accumulator. Repeated pool grants therefore divide the pool's bandwidth in inverse proportion to (cost+1)*length.
- R7: After a pool grant, let m be the smallest updated accumulator among the requesting pool inputs. Every pool accumulator is lowered by m and floored at zero. An idle pool input therefore builds no credit: when it returns, it shares grants with the busy one rather than taking a long run of grants.
- R8: When pool_cnt_i or any cost entry differs from its value in the previous cycle, that cycle's grant uses the current accumulators, and all accumulators are zero from the next cycle on.
- R9: No accumulator ever exceeds 2^8 * (2^8 - 1), the largest single addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request bit per input |
| len_i | input | 64 | Length per input, entry i at bits [8i+7:8i] |
| pool_cnt_i | input | 4 | Number of lowest-indexed inputs in the weighted pool |
| cost_i | input | 64 | Cost per input, entry i at bits [8i+7:8i] |
| grant_o | output | 8 | One-hot grant, registered |
| grant_vld_o | output | 1 | Grant valid, registered |

## Verification
With all inputs strict, full and sparse request masks show whether the highest index is chosen, and a mask mixing strict and pool requests shows whether the strict class wins. A continuously requesting pool with unequal costs, and then with unequal lengths, separates cost weighting from length weighting. An input that falls idle and then rejoins shows whether the floored rebase gives it banked credit. A cost change made mid-stream, a boundary count above eight and a run at maximum cost and length cover the clear-on-change rule, the clamp and the accumulator bound. A cycle-accurate behavioural model checks every cycle of all of these.

// File: rtl/pdarb_pkg.sv
package pdarb_pkg;

    // Which class supplies the grant in a given cycle
    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_STRICT = 2'd1,
        SRC_POOL   = 2'd2
    } src_e;

endpackage

// File: rtl/pdarb_strict_pick.sv
// Highest-index selection among strict requesters
module pdarb_strict_pick #(
    parameter int NUM = 8
) (
    input  logic [NUM-1:0] req_i,
    output logic [NUM-1:0] pick_oh_o,
    output logic           any_o
);
    always_comb begin
        pick_oh_o = '0;
        any_o     = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (req_i[i]) begin
                pick_oh_o    = '0;
                pick_oh_o[i] = 1'b1;
                any_o        = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pdarb_pool_pick.sv
// Lowest-accumulator selection among pool requesters, ties to lowest index
module pdarb_pool_pick #(
    parameter int NUM   = 8,
    parameter int ACC_W = 16,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0]       req_i,
    input  logic [NUM*ACC_W-1:0] acc_i,
    output logic [NUM-1:0]       pick_oh_o,
    output logic [IDX_W-1:0]     pick_idx_o,
    output logic                 any_o
);
    logic [ACC_W-1:0] best_val;

    always_comb begin
        best_val   = '1;
        pick_idx_o = '0;
        any_o      = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (req_i[i] && (!any_o || (acc_i[i*ACC_W +: ACC_W] < best_val))) begin
                best_val   = acc_i[i*ACC_W +: ACC_W];
                pick_idx_o = IDX_W'(i);
                any_o      = 1'b1;
            end
        end
        pick_oh_o = any_o ? (NUM'(1) << pick_idx_o) : '0;
    end
endmodule

// File: rtl/pdarb_min_find.sv
// Minimum of the masked entries of a flat vector
module pdarb_min_find #(
    parameter int NUM = 8,
    parameter int W   = 17
) (
    input  logic [NUM-1:0]   mask_i,
    input  logic [NUM*W-1:0] val_i,
    output logic [W-1:0]     min_o,
    output logic             any_o
);
    always_comb begin
        min_o = '1;
        any_o = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (mask_i[i] && (!any_o || (val_i[i*W +: W] < min_o))) begin
                min_o = val_i[i*W +: W];
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_dwrr_arb.sv
module prio_dwrr_arb
    import pdarb_pkg::*;
#(
    parameter int NUM    = 8,
    parameter int LEN_W  = 8,
    parameter int COST_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM-1:0]             req_i,
    input  logic [NUM*LEN_W-1:0]       len_i,
    input  logic [$clog2(NUM+1)-1:0]   pool_cnt_i,
    input  logic [NUM*COST_W-1:0]      cost_i,
    output logic [NUM-1:0]             grant_o,
    output logic                       grant_vld_o
);
    localparam int CNT_W = $clog2(NUM + 1);
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;
    localparam int ACC_W = COST_W + LEN_W;
    localparam int SUM_W = ACC_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX =
        ACC_W'((longint'(1) << COST_W) * ((longint'(1) << LEN_W) - 1));

    typedef struct packed {
        logic                  live;
        logic [NUM-1:0]        gnt;
        logic                  vld;
        logic [CNT_W-1:0]      cnt;
        logic [NUM*COST_W-1:0] cost;
        logic [NUM*ACC_W-1:0]  acc;
    } st_t;

    st_t st_d, st_q;

    // Class split
    logic [CNT_W-1:0] eff_cnt;
    logic [NUM-1:0]   pool_mask;
    logic [NUM-1:0]   strict_req;
    logic [NUM-1:0]   pool_req;

    always_comb eff_cnt = (pool_cnt_i > CNT_W'(NUM)) ? CNT_W'(NUM) : pool_cnt_i;

    for (genvar gi = 0; gi < NUM; gi++) begin : g_mask
        assign pool_mask[gi] = (CNT_W'(gi) < eff_cnt);
    end

    assign strict_req = req_i & ~pool_mask;
    assign pool_req   = req_i & pool_mask;

    // Pickers
    logic [NUM-1:0]   strict_oh;
    logic             strict_any;
    logic [NUM-1:0]   pool_oh;
    logic [IDX_W-1:0] pool_idx;
    logic             pool_any;

    pdarb_strict_pick #(.NUM(NUM)) u_strict (
        .req_i     (strict_req),
        .pick_oh_o (strict_oh),
        .any_o     (strict_any)
    );

    pdarb_pool_pick #(.NUM(NUM), .ACC_W(ACC_W)) u_pool (
        .req_i      (pool_req),
        .acc_i      (st_q.acc),
        .pick_oh_o  (pool_oh),
        .pick_idx_o (pool_idx),
        .any_o      (pool_any)
    );

    src_e src;
    always_comb begin
        if (strict_any)    src = SRC_STRICT;
        else if (pool_any) src = SRC_POOL;
        else               src = SRC_IDLE;
    end

    // Charge for the granted pool member
    logic [COST_W-1:0] cost_sel;
    logic [LEN_W-1:0]  len_sel;
    logic [COST_W:0]   cost_p1;
    logic [SUM_W-1:0]  add_val;

    always_comb begin
        cost_sel = cost_i[pool_idx*COST_W +: COST_W];
        len_sel  = len_i[pool_idx*LEN_W +: LEN_W];
        cost_p1  = {1'b0, cost_sel} + 1'b1;
        add_val  = SUM_W'(cost_p1) * SUM_W'(len_sel);
    end

    // Charged accumulators, rebase value and floored result
    logic [NUM*SUM_W-1:0] sum_flat;
    logic [NUM*ACC_W-1:0] norm_flat;
    logic [SUM_W-1:0]     min_val;
    logic                 min_any;

    for (genvar gi = 0; gi < NUM; gi++) begin : g_sum
        assign sum_flat[gi*SUM_W +: SUM_W] =
            {1'b0, st_q.acc[gi*ACC_W +: ACC_W]} + (pool_oh[gi] ? add_val : '0);
    end

    pdarb_min_find #(.NUM(NUM), .W(SUM_W)) u_min (
        .mask_i (pool_req),
        .val_i  (sum_flat),
        .min_o  (min_val),
        .any_o  (min_any)
    );

    for (genvar gi = 0; gi < NUM; gi++) begin : g_norm
        logic [SUM_W-1:0] s;
        assign s = sum_flat[gi*SUM_W +: SUM_W];
        assign norm_flat[gi*ACC_W +: ACC_W] =
            (!pool_mask[gi] || !min_any || (s <= min_val)) ? '0 : ACC_W'(s - min_val);
    end

    // Configuration change detection
    logic cfg_chg;
    assign cfg_chg = (pool_cnt_i != st_q.cnt) || (cost_i != st_q.cost);

    // Next state
    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        st_d.cnt  = pool_cnt_i;
        st_d.cost = cost_i;
        st_d.vld  = (src != SRC_IDLE);
        case (src)
            SRC_STRICT: st_d.gnt = strict_oh;
            SRC_POOL:   st_d.gnt = pool_oh;
            default:    st_d.gnt = '0;
        endcase
        if (cfg_chg)              st_d.acc = '0;
        else if (src == SRC_POOL) st_d.acc = norm_flat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o     = st_q.gnt;
    assign grant_vld_o = st_q.vld;

    // Checks on the registered outputs and state
    AST_RESET_IDLE: assert property (@(posedge clk)
        !st_q.live |-> (st_q.gnt == '0 && !st_q.vld && st_q.acc == '0)); // R1

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> (st_q.vld ? $countones(st_q.gnt) == 1 : st_q.gnt == '0)); // R2

    AST_GNT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> (st_q.vld == (|$past(req_i)) && (st_q.gnt & ~$past(req_i)) == '0)); // R2

    AST_STRICT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && (|$past(strict_req))) |->
            ((st_q.gnt & $past(strict_req)) != '0 &&
             ($past(strict_req) & ~(st_q.gnt | (st_q.gnt - NUM'(1)))) == '0)); // R4

    AST_POOL_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && !(|$past(strict_req)) && (|$past(pool_req))) |->
            ((st_q.gnt & $past(pool_req)) != '0)); // R5

    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(cfg_chg)) |-> st_q.acc == '0); // R8

    for (genvar gi = 0; gi < NUM; gi++) begin : g_bound
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.acc[gi*ACC_W +: ACC_W] <= ACC_MAX); // R9
    end

endmodule

// File: tb/prio_dwrr_arb_test.sv
module prio_dwrr_arb_test;
    localparam int NUM    = 8;
    localparam int LEN_W  = 8;
    localparam int COST_W = 8;
    localparam int CNT_W  = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NUM-1:0]        req = '0;
    logic [NUM*LEN_W-1:0]  len_f = '0;
    logic [CNT_W-1:0]      cnt = '0;
    logic [NUM*COST_W-1:0] cost_f = '0;
    logic [NUM-1:0]        gnt;
    logic                  vld;

    always #10 clk = ~clk;

    prio_dwrr_arb #(.NUM(NUM), .LEN_W(LEN_W), .COST_W(COST_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .len_i       (len_f),
        .pool_cnt_i  (cnt),
        .cost_i      (cost_f),
        .grant_o     (gnt),
        .grant_vld_o (vld)
    );

    int checks = 0;
    int errors = 0;
    int lens[NUM];
    int costs[NUM];
    int m_acc[NUM];
    int m_cost[NUM];
    int m_cnt = 0;
    int gcount[NUM];
    logic [NUM-1:0] exp_gnt;
    logic           exp_vld;

    task automatic drive_cfg();
        for (int i = 0; i < NUM; i++) begin
            len_f[i*LEN_W +: LEN_W]   = LEN_W'(lens[i]);
            cost_f[i*COST_W +: COST_W] = COST_W'(costs[i]);
        end
    endtask

    // Behavioural reference for one clock
    task automatic model_step();
        int  n;
        int  g;
        int  best;
        int  mn;
        bit  chg;
        bit  poolg;
        n = (int'(cnt) > NUM) ? NUM : int'(cnt);
        chg = (int'(cnt) != m_cnt);
        for (int i = 0; i < NUM; i++) if (costs[i] != m_cost[i]) chg = 1;
        g = -1;
        poolg = 0;
        for (int i = NUM - 1; i >= n; i--) if (req[i] && g < 0) g = i;
        if (g < 0) begin
            best = -1;
            for (int i = 0; i < n; i++)
                if (req[i] && (best < 0 || m_acc[i] < m_acc[best])) best = i;
            if (best >= 0) begin
                g = best;
                poolg = 1;
            end
        end
        exp_vld = (g >= 0);
        exp_gnt = (g >= 0) ? (NUM'(1) << g) : '0;
        if (chg) begin
            for (int i = 0; i < NUM; i++) m_acc[i] = 0;
        end else if (poolg) begin
            m_acc[g] += (costs[g] + 1) * lens[g];
            mn = -1;
            for (int i = 0; i < n; i++)
                if (req[i] && (mn < 0 || m_acc[i] < mn)) mn = m_acc[i];
            for (int i = 0; i < n; i++)
                m_acc[i] = (m_acc[i] > mn) ? m_acc[i] - mn : 0;
        end
        m_cnt = int'(cnt);
        for (int i = 0; i < NUM; i++) m_cost[i] = costs[i];
    endtask

    task automatic cyc(input logic [NUM-1:0] r, input string tag);
        req = r;
        drive_cfg();
        model_step();
        @(negedge clk);
        checks++;
        if (gnt !== exp_gnt || vld !== exp_vld) begin
            errors++;
            $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
                     tag, gnt, vld, exp_gnt, exp_vld);
        end
        if (vld === 1'b1)
            for (int i = 0; i < NUM; i++) if (gnt[i]) gcount[i]++;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < NUM; i++) gcount[i] = 0;
    endtask

    task automatic expect_true(input bit cond, input string tag, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM; i++) begin
            lens[i] = 1; costs[i] = 0; m_acc[i] = 0; m_cost[i] = 0;
        end
        clear_counts();
        req = 8'hFF;
        drive_cfg();
        repeat (3) @(negedge clk);
        // R1: reset state with requests present
        checks++;
        if (gnt !== '0 || vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: grant=%b vld=%b expected grant=0 vld=0", gnt, vld);
        end
        rst_n = 1'b1;

        // R3 / R4: all strict
        cnt = 4'd0;
        cyc(8'hFF, "R4_all_strict");
        cyc(8'h05, "R4_sparse");
        cyc(8'h00, "R2_idle");
        cyc(8'h01, "R3_zero_pool");
        cyc(8'h00, "R2_idle");

        // R6: unequal costs, pool of four
        cnt = 4'd4;
        costs[0] = 0; costs[1] = 1; costs[2] = 3; costs[3] = 7;
        cyc(8'h00, "R8_cfg_change");
        clear_counts();
        for (int k = 0; k < 60; k++) cyc(8'h0F, "R6_cost_share");
        expect_true(gcount[0] > gcount[1] && gcount[1] > gcount[2] && gcount[2] > gcount[3],
                    "R6 share order", gcount[3], gcount[0]);

        // R4: strict beats pool
        cyc(8'h1F, "R4_strict_over_pool");
        expect_true(gnt == 8'h10, "R4 strict over pool", int'(gnt), 16);
        cyc(8'h90, "R4_highest_strict");
        cyc(8'h8F, "R4_mix");

        // R5 / R6: unequal lengths, equal costs
        cnt = 4'd2;
        for (int i = 0; i < NUM; i++) costs[i] = 0;
        lens[0] = 4; lens[1] = 1;
        cyc(8'h00, "R8_cfg_change");
        cyc(8'h03, "R5_tie_low_index");
        expect_true(gnt == 8'h01, "R5 tie to lowest index", int'(gnt), 1);
        clear_counts();
        for (int k = 0; k < 40; k++) cyc(8'h03, "R6_length_share");
        expect_true(gcount[1] > 2 * gcount[0], "R6 length share", gcount[1], 2 * gcount[0]);

        // R7: idle input builds no credit
        lens[0] = 1; lens[1] = 1;
        for (int k = 0; k < 10; k++) cyc(8'h02, "R7_solo");
        clear_counts();
        for (int k = 0; k < 4; k++) cyc(8'h03, "R7_rejoin");
        expect_true(gcount[1] >= 1, "R7 no banked credit", gcount[1], 1);

        // R8: cost change clears accumulators
        lens[0] = 10; lens[1] = 1;
        cyc(8'h00, "R8_idle");
        for (int k = 0; k < 4; k++) cyc(8'h03, "R8_build");
        costs[1] = 1;
        cyc(8'h03, "R8_change_cycle");
        expect_true(gnt == 8'h02, "R8 change cycle uses old state", int'(gnt), 2);
        cyc(8'h03, "R8_after_clear");
        expect_true(gnt == 8'h01, "R8 cleared to tie", int'(gnt), 1);

        // R3: count above eight puts all in the pool
        for (int i = 0; i < NUM; i++) begin lens[i] = 1; costs[i] = 0; end
        cnt = 4'd15;
        cyc(8'h00, "R3_clamp_cfg");
        cyc(8'h81, "R3_clamp");
        expect_true(gnt == 8'h01, "R3 count clamp", int'(gnt), 1);
        cyc(8'h81, "R3_clamp");
        cyc(8'hFF, "R3_clamp");

        // R9: maximum charges
        for (int i = 0; i < NUM; i++) begin lens[i] = 255; costs[i] = 255 - i; end
        cnt = 4'd8;
        cyc(8'h00, "R9_cfg");
        for (int k = 0; k < 80; k++) cyc(8'hFF, "R9_max_charge");
        for (int k = 0; k < 40; k++) cyc(8'(8'h55 >> (k % 3)), "R9_mixed");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule